// File: doc/BRIEF.md
# Protected Memory Region Control Register with Lock

This block holds the 8-bit control register for the protected system-management memory region. For every memory cycle aimed at that region, it decides whether the cycle is served from DRAM or passed on to the PCI bus. The decision uses four fields of the register: enable, open, closed and lock. It also uses the CPU's management-mode indicator and a code/data indicator that arrive with each cycle. Checking whether an address falls inside the region is not done here. The surrounding decoder raises `cyc_vld` only for cycles that hit the region. It then uses `dram_sel` to steer each cycle.

Software programs the register through a simple write strobe. The register has fixed bits, and the stored value always carries a base segment of 2. The lock field is sticky. Once it is set, every later write keeps it set and forces the open field low. Only the power-on reset clears it. While the region is enabled, setting both open and closed is illegal. The block flags this with `cfg_err` and sends such cycles to PCI.

Top module: `smram_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge), `ctrl_q` reads 0x02 and `route_vld`, `dram_sel` and `cfg_err` are 0.
- R2: A write stores `(wr_data & 0x78) | 0x02`, visible on `ctrl_q` from the clock edge that samples `wr_en`. Bit 7 always reads 0 and bits 2:0 always read 2. The field positions are bit 6 open, bit 5 closed, bit 4 lock and bit 3 enable.
- R3: While bit 4 (lock) is 1, each write stores bit 4 as 1 and bit 6 as 0, and the other bits follow R2. Only a reset clears the lock.
- R4: A request (`cyc_vld` high at an edge) produces `route_vld` high for exactly the next cycle. In that cycle `dram_sel` holds the decision made from the register value and the `cyc_mgmt` and `cyc_code` inputs at the request edge. Without a request, `route_vld` and `dram_sel` are 0.
- R5: With bit 3 (enable) at 0, every cycle goes to PCI (`dram_sel` = 0).
- R6: Enabled and unlocked, with open 0 and `cyc_mgmt` 0, cycles go to PCI.
- R7: Enabled and unlocked, with open 1 and closed 0, both code and data cycles go to DRAM in either CPU mode.
- R8: Enabled with open 0, or locked, and with `cyc_mgmt` 1: if closed is 0, code and data go to DRAM. If closed is 1, code (`cyc_code` = 1) goes to DRAM and data goes to PCI.
- R9: Enabled and locked with `cyc_mgmt` 0, cycles go to PCI, even when the open bit was stored as 1.
- R10: `cfg_err` is 1 exactly when the register has enable, open and closed all set. Cycles in that state go to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| cyc_vld | input | 1 | A memory cycle to the protected region is presented |
| cyc_mgmt | input | 1 | CPU is in management mode for this cycle |
| cyc_code | input | 1 | 1 for a code fetch, 0 for a data reference |
| ctrl_q | output | 8 | Current register value |
| route_vld | output | 1 | Routing decision valid, one cycle after a request |
| dram_sel | output | 1 | 1 routes the cycle to DRAM, 0 to PCI |
| cfg_err | output | 1 | Illegal open-plus-closed configuration while enabled |

## Verification
The register is written with values that set stray bits, so the fixed-bit masking shows. Each register state then receives all four combinations of CPU mode and code/data. This separates the disabled, closed, open, illegal and locked routes from each other. A lock is set while open is also requested, to show that the locked state ignores the stale open bit outside management mode. Later writes then try to clear the lock and to raise open. A power-on reset follows, and the open route must work again afterwards. This shows that only reset releases the lock.

// File: rtl/smram_pkg.sv
// Package: field positions of the protected-region control register
// and the flag bundle passed from the register stage to the router.
package smram_pkg;
    localparam int unsigned CTRL_W     = 8;
    localparam int unsigned BIT_OPEN   = 6;
    localparam int unsigned BIT_CLOSED = 5;
    localparam int unsigned BIT_LOCK   = 4;
    localparam int unsigned BIT_EN     = 3;
    localparam logic [CTRL_W-1:0] WR_MASK   = 8'h78;
    localparam logic [CTRL_W-1:0] FIXED_SEG = 8'h02;
    localparam logic [CTRL_W-1:0] RST_VAL   = FIXED_SEG;

    typedef struct packed {
        logic open;
        logic closed;
        logic lock;
        logic en;
    } ctrl_flags_t;
endpackage

// File: rtl/smram_reg.sv
// Module: smram_reg
// Holds the control register. Writes are masked to the writable
// fields and the fixed segment is forced in. A set lock keeps itself
// set and forces open low on every later write.
// Assumes: rst_n is the power-on reset and is synchronous, active low.
module smram_reg
    import smram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output ctrl_flags_t       flags
);
    logic [CTRL_W-1:0] masked;
    logic [CTRL_W-1:0] next_val;

    // Purpose: build the value a write would store, including lock rules.
    always_comb begin
        masked   = (wr_data & WR_MASK) | FIXED_SEG;
        next_val = masked;
        if (ctrl_q[BIT_LOCK]) begin
            next_val[BIT_OPEN] = 1'b0;
            next_val[BIT_LOCK] = 1'b1;
        end
    end

    // Purpose: register update on write, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= RST_VAL;
        end else if (wr_en) begin
            ctrl_q <= next_val;
        end
    end

    // Purpose: expose the routing fields as a flag bundle.
    always_comb begin
        flags.open   = ctrl_q[BIT_OPEN];
        flags.closed = ctrl_q[BIT_CLOSED];
        flags.lock   = ctrl_q[BIT_LOCK];
        flags.en     = ctrl_q[BIT_EN];
    end
endmodule

// File: rtl/smram_route.sv
// Module: smram_route
// Decides DRAM or PCI for each presented cycle from the register flags,
// the CPU mode and the code/data kind. It registers the decision, so
// the result is valid one cycle after the request. Also reports the
// illegal open-plus-closed state.
// Assumes: flags come from the registered control value.
module smram_route
    import smram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctrl_flags_t flags,
    input  logic        cyc_vld,
    input  logic        cyc_mgmt,
    input  logic        cyc_code,
    output logic        route_vld,
    output logic        dram_sel,
    output logic        cfg_err
);
    logic illegal;
    logic open_path;
    logic mgmt_path;
    logic to_dram;

    // Purpose: evaluate the routing table for the current request.
    always_comb begin
        illegal   = flags.en && flags.open && flags.closed;
        open_path = flags.open && !flags.lock;
        mgmt_path = cyc_mgmt && (cyc_code || !flags.closed);
        to_dram   = flags.en && !illegal && (open_path || mgmt_path);
    end

    // Purpose: register the decision and its valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_vld <= 1'b0;
            dram_sel  <= 1'b0;
        end else begin
            route_vld <= cyc_vld;
            dram_sel  <= cyc_vld && to_dram;
        end
    end

    assign cfg_err = illegal;
endmodule

// File: rtl/smram_ctrl.sv
// Module: smram_ctrl (top)
// Control register and routing decision for the protected memory
// region. The address range check is done outside the block.
// Assumes: cyc_vld is raised only for cycles inside the region.
module smram_ctrl
    import smram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              cyc_vld,
    input  logic              cyc_mgmt,
    input  logic              cyc_code,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              route_vld,
    output logic              dram_sel,
    output logic              cfg_err
);
    ctrl_flags_t flags;

    smram_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .flags   (flags)
    );

    smram_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .cyc_vld   (cyc_vld),
        .cyc_mgmt  (cyc_mgmt),
        .cyc_code  (cyc_code),
        .route_vld (route_vld),
        .dram_sel  (dram_sel),
        .cfg_err   (cfg_err)
    );
endmodule

// File: rtl/smram_chk.sv
// Module: smram_chk
// Port-level properties of smram_ctrl, attached with bind.
module smram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       cyc_vld,
    input logic       cyc_mgmt,
    input logic       cyc_code,
    input logic [7:0] ctrl_q,
    input logic       route_vld,
    input logic       dram_sel,
    input logic       cfg_err
);
    // R1
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == 8'h02 && !route_vld && !dram_sel));

    // R2
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && ctrl_q[2:0] == 3'd2));

    // R2
    a_r2_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_q[4]) |=> (ctrl_q == (($past(wr_data) & 8'h78) | 8'h02)));

    // R3
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[4] |=> ctrl_q[4]);

    // R3
    a_r3_locked_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[4] && wr_en) |=> !ctrl_q[6]);

    // R4
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld |=> route_vld);

    // R4
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_vld |=> (!route_vld && !dram_sel));

    // R5
    a_r5_disabled_pci: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && !ctrl_q[3]) |=> !dram_sel);

    // R9
    a_r9_locked_user_pci: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && ctrl_q[4] && !cyc_mgmt) |=> !dram_sel);

    // R10
    a_r10_illegal_pci: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && cfg_err) |=> !dram_sel);

    // R8
    a_r8_closed_data_pci: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && ctrl_q[5] && !cyc_code && !(ctrl_q[6] && !ctrl_q[4])) |=> !dram_sel);
endmodule

bind smram_ctrl smram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cyc_vld   (cyc_vld),
    .cyc_mgmt  (cyc_mgmt),
    .cyc_code  (cyc_code),
    .ctrl_q    (ctrl_q),
    .route_vld (route_vld),
    .dram_sel  (dram_sel),
    .cfg_err   (cfg_err)
);

// File: tb/test_smram_ctrl.sv
// Scoreboard bench: the driver queues the expected route for each
// cycle, and the monitor compares it when route_vld appears.
module test_smram_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cyc_vld = 1'b0;
    logic       cyc_mgmt = 1'b0;
    logic       cyc_code = 1'b0;
    logic [7:0] ctrl_q;
    logic       route_vld;
    logic       dram_sel;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mreg = 8'h02;
    bit    q_exp[$];
    string q_tag[$];

    always #5 clk = ~clk;

    smram_ctrl i_smram_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cyc_vld(cyc_vld), .cyc_mgmt(cyc_mgmt), .cyc_code(cyc_code),
        .ctrl_q(ctrl_q), .route_vld(route_vld), .dram_sel(dram_sel),
        .cfg_err(cfg_err)
    );

    // Expected route from the requirement table.
    function automatic bit exp_route(input logic [7:0] r, input bit m, input bit c);
        if (!r[3]) return 1'b0;              // R5
        if (r[6] && r[5]) return 1'b0;       // R10
        if (!r[4] && r[6]) return 1'b1;      // R7
        if (m) return r[5] ? c : 1'b1;       // R8
        return 1'b0;                         // R6 / R9
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        mreg = 8'h02;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        mreg = (d & 8'h78) | 8'h02;
        if (mreg[4] === 1'b1 && 1'b0) mreg = mreg;
    endtask

    // Lock-aware model update applied by the writer below.
    task automatic write_reg(input logic [7:0] d, input string tag);
        logic [7:0] v;
        bit was_locked;
        was_locked = mreg[4];
        do_write(d);
        v = (d & 8'h78) | 8'h02;
        if (was_locked) v = (v & 8'hBF) | 8'h10;
        mreg = v;
        check(tag, ctrl_q, mreg);
        check({tag, " err"}, cfg_err, mreg[3] & mreg[6] & mreg[5]);
    endtask

    task automatic do_cycle(input bit m, input bit c, input string tag);
        @(negedge clk);
        cyc_vld = 1'b1; cyc_mgmt = m; cyc_code = c;
        q_exp.push_back(exp_route(mreg, m, c));
        q_tag.push_back(tag);
        @(negedge clk);
        cyc_vld = 1'b0;
    endtask

    task automatic all_cycles(input string tag);
        for (int k = 0; k < 4; k++) do_cycle(k[1], k[0], tag);
    endtask

    // Monitor: compare each valid result with the queue head.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && route_vld) begin
                if (q_exp.size() == 0) begin
                    check("R4 unexpected route_vld", 1, 0);
                end else begin
                    check(q_tag.pop_front(), dram_sel, q_exp.pop_front());
                end
            end else if (rst_n && dram_sel) begin
                check("R4 dram_sel without valid", dram_sel, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset ctrl_q", ctrl_q, 8'h02);
        check("R1 reset route_vld", route_vld, 0);
        check("R1 reset cfg_err", cfg_err, 0);

        all_cycles("R5 disabled");
        write_reg(8'h87, "R2 stray bits");
        write_reg(8'hAD, "R2 closed+enable");
        all_cycles("R6/R8 closed");
        write_reg(8'h48, "R2 open+enable");
        all_cycles("R7 open");
        write_reg(8'h68, "R10 illegal");
        all_cycles("R10 illegal route");
        write_reg(8'h08, "R2 enable only");
        all_cycles("R6/R8 enabled");
        write_reg(8'h58, "R3 lock with open");
        all_cycles("R9/R8 locked open stored");
        write_reg(8'h48, "R3 lock retained");
        write_reg(8'h00, "R3 lock survives zero");
        write_reg(8'h68, "R3 open forced low");
        all_cycles("R8/R9 locked closed");
        repeat (3) @(negedge clk);
        check("R4 queue drained", q_exp.size(), 0);

        do_reset();
        #1;
        check("R3 reset clears lock", ctrl_q, 8'h02);
        write_reg(8'h48, "R3 open after reset");
        all_cycles("R7 open after reset");
        repeat (3) @(negedge clk);
        check("R4 queue drained end", q_exp.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule